// File: doc/BRIEF.md
# Inbound Read Termination Controller

This block sits on the target side of a bridge that accepts inbound memory reads headed for system DRAM. For each inbound read it decides whether to accept the burst, retry it or disconnect it. The decision depends on the burst address and on flags that report outbound traffic (processor- or hub-originated writes and reads to the same bus) still in flight. Reads that lose an ordering hazard against an outbound write are parked in a single delayed-transaction slot. One snoop is sent toward the processor bus for each parked read, and the read may finish only when the master repeats it exactly once the hazard is gone.

During an accepted burst the block fetches ahead by snooping cache lines, one `snoop_req` pulse per 32-byte line. It never goes further than three lines past the line being read and never into the next 2 KB page. Read data moves on a valid/ready handshake. The master raises `dat_vld` when it can take a dword, and a dword moves on each clock edge where `dat_vld` and `dat_rdy` are both high. `dat_rdy` is high only while a fetched dword is waiting. The master may hold `dat_vld` low for as long as it likes, which stalls the burst with no other effect. The master ends a burst by transferring a dword with `dat_last` high.

Request command encoding: 0 is plain memory read, 1 is read line, 2 is read multiple. Code 3 is handled like read line.

Top module: `irt_ctrl`

## Requirements
- R1: After reset, `retry`, `disconnect`, `snoop_req`, `dt_valid` and `dat_rdy` are all low.
- R2: A request seen with `ob_wr_pend` high is retried. `retry` is a one-cycle pulse in the third cycle after the cycle in which `frame_start` is high, and `dat_rdy` stays low.
- R3: A retry caused by an outbound write, with the slot empty, fills the delayed-transaction slot. `dt_valid` rises together with exactly one `snoop_req` pulse, and no further snoop follows while the slot waits.
- R4: While `dt_valid` is high, a request whose address or command differs from the parked one is retried after three cycles, and the slot is kept. An exact repeat that is ready is accepted and clears `dt_valid`.
- R5: A parked read is ready only after `snoop_done` has been seen and `ob_wr_pend` has been seen low on a cycle before the repeat's frame cycle. Otherwise the repeat is retried after three cycles.
- R6: If `ob_wr_pend` rises during an accepted burst before any dword has transferred, `retry` pulses on the next cycle. The burst's start address and command are parked with one snoop pulse.
- R7: During a burst, `ob_rd_pend` sampled high on 32 consecutive clock edges causes a `retry` pulse right after the 32nd edge. A low sample restarts the count.
- R8: Snoop-ahead issues one `snoop_req` pulse per line, starting at the line of the start address. It keeps at most the current line plus three lines fetched and never fetches past the 2 KB page holding the start address.
- R9: For commands 1 to 3, `ob_wr_pend` sampled high after at least one dword has transferred stops snoop-ahead. `disconnect` pulses one cycle after the last already-fetched dword transfers.
- R10: For command 0, `ob_wr_pend` rising after data has transferred has no effect: snoop-ahead and transfers continue with no `retry` or `disconnect`.
- R11: A burst that reaches the end of its 2 KB page transfers every dword up to the page end, then `disconnect` pulses one cycle after the final dword. No line of the next page is snooped.
- R12: A dword transferred with `dat_last` high ends the burst with neither `retry` nor `disconnect`.
- R13: `dat_rdy` is high only during an accepted burst with a fetched, untransferred dword. It is low in any cycle where `retry` or `disconnect` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse: a new inbound read request |
| req_addr | input | AW | Byte start address of the request |
| req_cmd | input | 2 | Read command code (0 plain, 1 line, 2 multiple) |
| dat_vld | input | 1 | Master can accept a read dword |
| dat_last | input | 1 | Current dword is the last the master wants |
| dat_rdy | output | 1 | A fetched dword is available |
| ob_wr_pend | input | 1 | An outbound write is pending |
| ob_rd_pend | input | 1 | An outbound read is pending |
| snoop_done | input | 1 | Processor-bus snoop for the parked read finished |
| retry | output | 1 | Retry termination pulse |
| disconnect | output | 1 | Disconnect termination pulse |
| snoop_req | output | 1 | Snoop request pulse, one per cache line |
| dt_valid | output | 1 | Delayed-transaction slot occupied |

## Verification
The bench builds the block with a 13-bit address, so four 2 KB pages exist. That lets the sweeps put a start address in every page's final lines and hit each page end from many dword offsets. The other parameters keep their defaults: the full 32-clock read-collision window, the 3-cycle retry delay and the three-line snoop-ahead window. With these values, the expected beat, snoop and termination counts for every start offset follow from simple address arithmetic in the bench.

// File: rtl/irt_pkg.sv
package irt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RWAIT = 2'd1,
    ST_XFER  = 2'd2
  } irt_st_e;

  localparam logic [1:0] CMD_PLAIN = 2'd0;
  localparam logic [1:0] CMD_LINE  = 2'd1;
  localparam logic [1:0] CMD_MULTI = 2'd2;
endpackage

// File: rtl/irt_dt_rec.sv
module irt_dt_rec #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [AW-1:0] cap_addr,
  input  logic [1:0]    cap_cmd,
  input  logic          clr,
  input  logic          wr_pend,
  input  logic          snp_done,
  input  logic [AW-1:0] q_addr,
  input  logic [1:0]    q_cmd,
  output logic          vld,
  output logic          hit
);
  logic [AW-1:0] r_addr;
  logic [1:0]    r_cmd;
  logic          drained;
  logic          snp_ok;

  // ready only on exact repeat, after drain and snoop completion were registered
  assign hit = vld && (q_addr == r_addr) && (q_cmd == r_cmd) && drained && snp_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= 1'b0;
      r_addr  <= '0;
      r_cmd   <= '0;
      drained <= 1'b0;
      snp_ok  <= 1'b0;
    end else if (cap) begin
      vld     <= 1'b1;
      r_addr  <= cap_addr;
      r_cmd   <= cap_cmd;
      drained <= 1'b0;
      snp_ok  <= 1'b0;
    end else if (clr) begin
      vld <= 1'b0;
    end else if (vld) begin
      if (!wr_pend)  drained <= 1'b1;
      if (snp_done)  snp_ok  <= 1'b1;
    end
  end
endmodule

// File: rtl/irt_ctmo.sv
module irt_ctmo #(
  parameter int TMO = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pend,
  output logic fire
);
  localparam int CW = (TMO > 1) ? $clog2(TMO) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO - 1);

  logic [CW-1:0] cnt;

  assign fire = en && pend && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (en && pend && !fire) cnt <= cnt + 1'b1;
    else                          cnt <= '0;
  end
endmodule

// File: rtl/irt_ctrl.sv
module irt_ctrl
  import irt_pkg::*;
#(
  parameter int AW     = 16,
  parameter int LINE_B = 32,
  parameter int PAGE_B = 2048,
  parameter int AHEAD  = 3,
  parameter int TMO    = 32,
  parameter int RDLY   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_cmd,
  input  logic          dat_vld,
  input  logic          dat_last,
  output logic          dat_rdy,
  input  logic          ob_wr_pend,
  input  logic          ob_rd_pend,
  input  logic          snoop_done,
  output logic          retry,
  output logic          disconnect,
  output logic          snoop_req,
  output logic          dt_valid
);
  localparam int LB  = $clog2(LINE_B);
  localparam int PB  = $clog2(PAGE_B);
  localparam int XW  = AW + 1;
  localparam int RCW = (RDLY > 2) ? $clog2(RDLY) : 1;
  localparam logic [XW-1:0]  LINE_X = XW'(LINE_B);
  localparam logic [XW-1:0]  WIN_X  = XW'((AHEAD + 1) * LINE_B);
  localparam logic [XW-1:0]  PAGE_X = XW'(PAGE_B);
  localparam logic [XW-1:0]  BEAT_X = XW'(4);
  localparam logic [RCW-1:0] RLAST  = RCW'(RDLY - 2);

  irt_st_e       st;
  logic [RCW-1:0] rcnt;
  logic [XW-1:0] cur, fend, plim;
  logic [AW-1:0] saddr;
  logic [1:0]    bcmd;
  logic          got_data, stop;

  logic in_idle, in_xfer, dt_hit, tmo_fire;
  logic go_rwait, cap_f, cap_x, dt_clr;
  logic early_wr, stop_now, end_now, ahead_ok, beat;
  logic [XW-1:0] cur_line;

  assign in_idle  = (st == ST_IDLE);
  assign in_xfer  = (st == ST_XFER);
  assign cur_line = {cur[XW-1:LB], {LB{1'b0}}};

  // frame-time decision
  assign go_rwait = ob_wr_pend || (dt_valid && !dt_hit);
  assign cap_f    = in_idle && frame_start && ob_wr_pend && !dt_valid;
  assign dt_clr   = in_idle && frame_start && !ob_wr_pend && dt_valid && dt_hit;

  // in-burst hazards
  assign early_wr = in_xfer && ob_wr_pend && !got_data;
  assign cap_x    = early_wr && !dt_valid;
  assign stop_now = ob_wr_pend && got_data && (bcmd != CMD_PLAIN);
  assign end_now  = in_xfer && got_data && (cur == fend) && (stop || fend == plim);
  assign dat_rdy  = in_xfer && (cur < fend) && !early_wr && !tmo_fire;
  assign beat     = dat_vld && dat_rdy;
  assign ahead_ok = in_xfer && !stop && !stop_now && !early_wr && !tmo_fire &&
                    !end_now && !(beat && dat_last) &&
                    (fend < plim) && ((fend - cur_line) < WIN_X);

  irt_dt_rec #(.AW(AW)) u_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap_f || cap_x),
    .cap_addr (in_idle ? req_addr : saddr),
    .cap_cmd  (in_idle ? req_cmd : bcmd),
    .clr      (dt_clr),
    .wr_pend  (ob_wr_pend),
    .snp_done (snoop_done),
    .q_addr   (req_addr),
    .q_cmd    (req_cmd),
    .vld      (dt_valid),
    .hit      (dt_hit)
  );

  irt_ctmo #(.TMO(TMO)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_xfer),
    .pend  (ob_rd_pend),
    .fire  (tmo_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      rcnt       <= '0;
      cur        <= '0;
      fend       <= '0;
      plim       <= '0;
      saddr      <= '0;
      bcmd       <= CMD_PLAIN;
      got_data   <= 1'b0;
      stop       <= 1'b0;
      retry      <= 1'b0;
      disconnect <= 1'b0;
      snoop_req  <= 1'b0;
    end else begin
      retry      <= 1'b0;
      disconnect <= 1'b0;
      snoop_req  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (frame_start) begin
            if (go_rwait) begin
              st        <= ST_RWAIT;
              rcnt      <= '0;
              snoop_req <= cap_f;
            end else begin
              st       <= ST_XFER;
              cur      <= {1'b0, req_addr[AW-1:2], 2'b00};
              fend     <= {1'b0, req_addr[AW-1:LB], {LB{1'b0}}};
              plim     <= {1'b0, req_addr[AW-1:PB], {PB{1'b0}}} + PAGE_X;
              saddr    <= req_addr;
              bcmd     <= req_cmd;
              got_data <= 1'b0;
              stop     <= 1'b0;
            end
          end
        end
        ST_RWAIT: begin
          if (rcnt == RLAST) begin
            retry <= 1'b1;
            st    <= ST_IDLE;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (early_wr) begin
            retry     <= 1'b1;
            snoop_req <= !dt_valid;
            st        <= ST_IDLE;
          end else if (tmo_fire) begin
            retry <= 1'b1;
            st    <= ST_IDLE;
          end else if (end_now) begin
            disconnect <= 1'b1;
            st         <= ST_IDLE;
          end else begin
            if (beat) begin
              cur      <= cur + BEAT_X;
              got_data <= 1'b1;
              if (dat_last) st <= ST_IDLE;
            end
            if (stop_now) stop <= 1'b1;
            if (ahead_ok) begin
              snoop_req <= 1'b1;
              fend      <= fend + LINE_X;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irt_ctrl_chk.sv
module irt_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic retry,
  input logic disconnect,
  input logic snoop_req,
  input logic dt_valid,
  input logic dat_rdy,
  input logic ob_wr_pend
);
  p_retry_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    retry |=> !retry);

  p_dt_one_snoop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dt_valid) |-> snoop_req);

  p_dt_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_valid && ob_wr_pend) |=> dt_valid);

  p_disc_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect |=> !disconnect);

  p_term_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry && disconnect));

  p_no_rdy_on_term_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (retry || disconnect) |-> !dat_rdy);
endmodule

bind irt_ctrl irt_ctrl_chk u_chk (.*);

// File: tb/irt_ctrl_tb_top.sv
module irt_ctrl_tb_top;
  localparam int AW  = 13;
  localparam int PG  = 2048;
  localparam int TMO = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_start, dat_vld, dat_last, ob_wr_pend, ob_rd_pend, snoop_done;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_cmd;
  logic          dat_rdy, retry, disconnect, snoop_req, dt_valid;

  int n_chk = 0, n_bad = 0;
  int n_snp = 0, n_rty = 0, n_dsc = 0, n_beat = 0;

  always #5 clk = ~clk;

  irt_ctrl #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .req_addr(req_addr),
    .req_cmd(req_cmd), .dat_vld(dat_vld), .dat_last(dat_last), .dat_rdy(dat_rdy),
    .ob_wr_pend(ob_wr_pend), .ob_rd_pend(ob_rd_pend), .snoop_done(snoop_done),
    .retry(retry), .disconnect(disconnect), .snoop_req(snoop_req), .dt_valid(dt_valid)
  );

  always @(posedge clk) begin
    if (snoop_req)         n_snp++;
    if (retry)             n_rty++;
    if (disconnect)        n_dsc++;
    if (dat_vld && dat_rdy) n_beat++;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input int a, input int c);
    frame_start = 1'b1;
    req_addr    = AW'(a);
    req_cmd     = 2'(c);
    tick();
    frame_start = 1'b0;
  endtask

  task automatic check_retry3(input string tag);
    chk({tag, " retry cycle1"}, retry, 0);
    chk({tag, " rdy during wait"}, dat_rdy, 0);
    tick();
    chk({tag, " retry cycle2"}, retry, 0);
    tick();
    chk({tag, " retry cycle3"}, retry, 1);
    tick();
    chk({tag, " retry cycle4"}, retry, 0);
  endtask

  task automatic finish_burst();
    int lim = 0;
    dat_vld  = 1'b1;
    dat_last = 1'b1;
    while (!dat_rdy && lim < 50) begin tick(); lim++; end
    tick();
    dat_vld  = 1'b0;
    dat_last = 1'b0;
  endtask

  task automatic wait_disc();
    int lim = 0;
    while (!disconnect && lim < 400) begin tick(); lim++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s0, r0, d0, b0, snp_fin, base, a;
    rst_n = 1'b0; frame_start = 0; dat_vld = 0; dat_last = 0;
    ob_wr_pend = 0; ob_rd_pend = 0; snoop_done = 0; req_addr = '0; req_cmd = '0;
    tick(4);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 retry", retry, 0);
    chk("R1 disconnect", disconnect, 0);
    chk("R1 snoop_req", snoop_req, 0);
    chk("R1 dt_valid", dt_valid, 0);
    chk("R1 dat_rdy", dat_rdy, 0);

    // R8, R12, R13: snoop window sweep near every page end
    for (int pg = 0; pg < 4; pg++)
      for (int ln = 1; ln <= 6; ln++)
        for (int o = 0; o < 3; o++) begin
          a = pg * PG + PG - ln * 32 + (o == 0 ? 0 : (o == 1 ? 12 : 28));
          s0 = n_snp; r0 = n_rty; d0 = n_dsc;
          issue(a, pg % 3);
          b0 = n_beat;
          tick(8);
          chk("R8 snoop window", n_snp - s0, (ln < 4) ? ln : 4);
          chk("R13 stalled no beats", n_beat - b0, 0);
          chk("R13 rdy with data", dat_rdy, 1);
          finish_burst();
          tick(2);
          chk("R12 last beat count", n_beat - b0, 1);
          chk("R12 no retry", n_rty - r0, 0);
          chk("R12 no disconnect", n_dsc - d0, 0);
        end

    // R11 page crossing from many dword offsets
    for (int n = 1; n <= 40; n++) begin
      a = (n % 4) * PG + PG - 4 * n;
      s0 = n_snp; r0 = n_rty; d0 = n_dsc; b0 = n_beat;
      issue(a, 1);
      dat_vld = 1'b1;
      wait_disc();
      dat_vld = 1'b0;
      tick();
      chk("R11 beats to page end", n_beat - b0, n);
      chk("R11 snoops stay in page", n_snp - s0, (4 * n + 31) / 32);
      chk("R11 one disconnect", n_dsc - d0, 1);
      chk("R11 no retry", n_rty - r0, 0);
      tick();
    end

    // R9 outbound write after data, line and multiple commands
    for (int c = 1; c <= 2; c++)
      for (int k = 1; k <= 17; k += 4) begin
        a = PG + 512 + 4 * (k % 8);
        base = a - (a % 32);
        s0 = n_snp; r0 = n_rty; d0 = n_dsc;
        issue(a, c);
        b0 = n_beat;
        dat_vld = 1'b1;
        while (n_beat - b0 < k) tick();
        ob_wr_pend = 1'b1;
        snp_fin = n_snp - s0 + int'(snoop_req);
        wait_disc();
        dat_vld = 1'b0;
        tick();
        ob_wr_pend = 1'b0;
        chk("R9 snoop-ahead stopped", n_snp - s0, snp_fin);
        chk("R9 beats up to fetched end", n_beat - b0, (base + snp_fin * 32 - a) / 4);
        chk("R9 one disconnect", n_dsc - d0, 1);
        chk("R9 no retry", n_rty - r0, 0);
        tick(2);
      end

    // R10 plain read ignores outbound write after data
    r0 = n_rty; d0 = n_dsc;
    issue(PG + 1024, 0);
    b0 = n_beat;
    dat_vld = 1'b1;
    while (n_beat - b0 < 3) tick();
    ob_wr_pend = 1'b1;
    tick(12);
    chk("R10 beats continue", n_beat - b0, 15);
    chk("R10 rdy stays", dat_rdy, 1);
    finish_burst();
    ob_wr_pend = 1'b0;
    tick(2);
    chk("R10 no disconnect", n_dsc - d0, 0);
    chk("R10 no retry", n_rty - r0, 0);

    // R2, R3, R4, R5: write pending at frame, parked read lifecycle
    s0 = n_snp;
    ob_wr_pend = 1'b1;
    issue(3 * PG + 96, 1);
    chk("R3 dt_valid set", dt_valid, 1);
    chk("R3 snoop with capture", snoop_req, 1);
    check_retry3("R2");
    tick(3);
    chk("R3 exactly one snoop", n_snp - s0, 1);
    snoop_done = 1'b1; tick(); snoop_done = 1'b0; tick();
    ob_wr_pend = 1'b0;
    issue(3 * PG + 96, 1);
    check_retry3("R5 drain not yet seen");
    chk("R5 slot kept", dt_valid, 1);
    issue(3 * PG + 100, 1);
    check_retry3("R4 address mismatch");
    issue(3 * PG + 96, 2);
    check_retry3("R4 command mismatch");
    chk("R4 slot kept", dt_valid, 1);
    r0 = n_rty;
    issue(3 * PG + 96, 1);
    chk("R4 exact repeat clears slot", dt_valid, 0);
    tick(4);
    chk("R4 repeat accepted rdy", dat_rdy, 1);
    chk("R4 repeat no retry", n_rty - r0, 0);
    finish_burst();
    tick();
    // R5 snoop completion required
    ob_wr_pend = 1'b1;
    issue(3 * PG + 256, 2);
    check_retry3("R2 second capture");
    ob_wr_pend = 1'b0;
    tick(2);
    issue(3 * PG + 256, 2);
    check_retry3("R5 snoop not done");
    snoop_done = 1'b1; tick(); snoop_done = 1'b0;
    issue(3 * PG + 256, 2);
    chk("R5 accepted after snoop", dt_valid, 0);
    tick(3);
    chk("R5 rdy after accept", dat_rdy, 1);
    finish_burst();
    tick();

    // R6 outbound write before first data
    for (int c = 0; c < 3; c++) begin
      s0 = n_snp;
      issue(2 * PG + 64 + 32 * c, c);
      ob_wr_pend = 1'b1;
      s0 = n_snp + int'(snoop_req);
      tick();
      chk("R6 retry next cycle", retry, 1);
      chk("R6 parked", dt_valid, 1);
      chk("R6 snoop for parked", snoop_req, 1);
      ob_wr_pend = 1'b0;
      tick();
      chk("R6 one snoop", n_snp - s0, 1);
      snoop_done = 1'b1; tick(); snoop_done = 1'b0; tick();
      r0 = n_rty;
      issue(2 * PG + 64 + 32 * c, c);
      chk("R6 repeat of parked start accepted", dt_valid, 0);
      tick(3);
      chk("R6 repeat no retry", n_rty - r0, 0);
      finish_burst();
      tick();
    end

    // R7 read-collision timer, onset sweep
    for (int c = 1; c <= 4; c++) begin
      issue(PG + 128, 1);
      tick(c - 1);
      ob_rd_pend = 1'b1;
      tick(TMO - 1);
      chk("R7 no retry before expiry", retry, 0);
      tick();
      chk("R7 retry at expiry", retry, 1);
      ob_rd_pend = 1'b0;
      tick();
      chk("R7 pulse ends", retry, 0);
    end
    // R7 low sample restarts count
    r0 = n_rty;
    issue(PG + 192, 2);
    ob_rd_pend = 1'b1;
    tick(TMO - 1);
    ob_rd_pend = 1'b0;
    tick();
    ob_rd_pend = 1'b1;
    tick(TMO - 1);
    chk("R7 restarted count no retry", n_rty - r0 + int'(retry), 0);
    ob_rd_pend = 1'b0;
    finish_burst();
    tick(2);
    chk("R7 burst ended cleanly", n_rty - r0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule